// File: doc/BRIEF.md
# Condition-field mask test unit

This execute unit performs four related operations on the 4-bit fields of a 32-bit condition register. Each operation compares the bits of one field against a polarity pattern (`mode`), using only the bit positions a 4-bit `mask` enables. It then either collapses the four compare terms into one bit, or writes them back as a whole field. The 2-bit `variant` input picks one of four operations. The field-to-integer operation reduces a field to the LSB of a 64-bit result. The integer-to-field operation builds a field from the LSB of an integer operand. The field-to-bit operation reduces a field into one addressed condition bit. The field-to-field operation builds a field from another field.

The datapath is combinational, and one output register stage holds its results. An issued operation (`op_valid` high) shows its new condition register, integer result and write enables one cycle later. The surrounding pipeline feeds in the current condition register and the integer operand, and it commits the outputs when the enables are set. It also supplies the overflow-summary bit that is used when the record flag is set.

Top module: `cond_field_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero and both write enables are low.
- R2: Logical field k occupies `cr_in[4k+3:4k]`. Field bit i pairs with `mask[i]` and `mode[i]`. Term i is `mask[i] & (mode[i] == source bit i)`. A reduction ORs the four terms when `merge`=1 and ANDs them when `merge`=0.
- R3: Variant 2'b00 (field to integer) reduces field `src_field`. It places the reduced bit at `int_res[0]` and zeros bits 63:1, sets `int_wr` and leaves `int_wr` low for every other variant.
- R4: In variant 2'b00 with `rc`=1, field 0 becomes {0, r, ~r, `so_in`}. Bit 3 is negative, bit 2 is positive, bit 1 is zero, bit 0 is the summary. r is the reduced bit, and `cr_wr` is set. With `rc`=0, `cr_new` equals `cr_in` and `cr_wr` is low.
- R5: Variant 2'b01 (integer to field) compares all four positions against `int_src[0]`. When `ra_sel` is zero, the compare bit is 0 whatever `int_src` holds. The result field is written to `dst_field`.
- R6: Variant 2'b11 (field to field) compares field `src_field` and writes the resulting field to `dst_field`.
- R7: For variants 2'b01 and 2'b11, the new field is the terms ORed with (`merge` ? old destination bits outside `mask` : 0). All other fields equal `cr_in`.
- R8: Variant 2'b10 (field to bit) reduces field `src_field` into one condition bit. `bit_target[4:2]` names the field. `bit_target[1:0]`=0..3 selects field bit 3..0, so 0 selects the negative bit. No other bit changes.
- R9: Results of an operation issued in cycle t appear in cycle t+1 with `cr_wr` set for variants 01, 10, 11. A cycle without `op_valid` clears both enables and holds `cr_new` and `int_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| variant | input | 2 | Operation select (00 f->int, 01 int->f, 10 f->bit, 11 f->f) |
| merge | input | 1 | OR-reduce / keep unmasked bits when 1 |
| rc | input | 1 | Record flag for the field-to-integer variant |
| mask | input | 4 | Per-bit enable of the compare |
| mode | input | 4 | Per-bit polarity pattern |
| src_field | input | 3 | Source field index |
| dst_field | input | 3 | Destination field index |
| bit_target | input | 5 | Field and bit for the field-to-bit variant |
| ra_sel | input | 5 | Integer operand selector; zero forces a zero source |
| int_src | input | 64 | Integer operand |
| so_in | input | 1 | Overflow-summary bit for field 0 |
| cr_in | input | 32 | Current condition register |
| cr_new | output | 32 | Resulting condition register |
| int_res | output | 64 | Integer result |
| cr_wr | output | 1 | Condition register write enable |
| int_wr | output | 1 | Integer write enable |

## Verification
The bench builds the unit with its default parameters: 4-bit fields, eight fields and a 64-bit integer path. With these values every mask and every mode, all eight field indices and all 32 bit targets can be swept exhaustively in a short run. Each variant is run over all 256 mask/mode pairs under both merge settings, against randomized condition contents. The record flag, the zero-selector immediate path and idle-cycle holding are each covered by their own scenario.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    typedef enum logic [1:0] {
        VAR_F2I = 2'b00,
        VAR_I2F = 2'b01,
        VAR_F2B = 2'b10,
        VAR_F2F = 2'b11
    } cfu_variant_e;
endpackage

// File: rtl/cfu_term_reduce.sv
module cfu_term_reduce #(
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] field_in,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] mode,
    input  logic               use_or,
    output logic [FIELD_W-1:0] terms,
    output logic               reduced
);
    always_comb begin
        for (int i = 0; i < FIELD_W; i++) begin
            terms[i] = mask[i] & (mode[i] == field_in[i]);
        end
        reduced = use_or ? (|terms) : (&terms);
    end
endmodule

// File: rtl/cfu_field_merge.sv
module cfu_field_merge #(
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] terms,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] old_field,
    input  logic               keep,
    output logic [FIELD_W-1:0] new_field
);
    always_comb begin
        new_field = terms | (keep ? (old_field & ~mask) : '0);
    end
endmodule

// File: rtl/cond_field_unit.sv
module cond_field_unit
    import cfu_pkg::*;
#(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 8,
    parameter int XLEN       = 64,
    parameter int RSEL_W     = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   op_valid,
    input  logic [1:0]                             variant,
    input  logic                                   merge,
    input  logic                                   rc,
    input  logic [FIELD_W-1:0]                     mask,
    input  logic [FIELD_W-1:0]                     mode,
    input  logic [$clog2(NUM_FIELDS)-1:0]          src_field,
    input  logic [$clog2(NUM_FIELDS)-1:0]          dst_field,
    input  logic [$clog2(NUM_FIELDS)+$clog2(FIELD_W)-1:0] bit_target,
    input  logic [RSEL_W-1:0]                      ra_sel,
    input  logic [XLEN-1:0]                        int_src,
    input  logic                                   so_in,
    input  logic [FIELD_W*NUM_FIELDS-1:0]          cr_in,
    output logic [FIELD_W*NUM_FIELDS-1:0]          cr_new,
    output logic [XLEN-1:0]                        int_res,
    output logic                                   cr_wr,
    output logic                                   int_wr
);
    localparam int CR_W   = FIELD_W * NUM_FIELDS;
    localparam int FSEL_W = $clog2(NUM_FIELDS);
    localparam int BSEL_W = $clog2(FIELD_W);
    localparam int CRI_W  = FSEL_W + BSEL_W;

    typedef struct packed {
        logic [CR_W-1:0] cr;
        logic [XLEN-1:0] iv;
        logic            cr_wr;
        logic            int_wr;
    } cfu_state_t;

    cfu_state_t st_d, st_q;

    cfu_variant_e        var_e;
    logic [CRI_W-1:0]    src_base, dst_base, bit_pos;
    logic [FIELD_W-1:0]  src_fld, dst_old, cmp_fld, terms, merged, rec_fld;
    logic                int_bit, reduced;

    assign var_e    = cfu_variant_e'(variant);
    assign src_base = {src_field, {BSEL_W{1'b0}}};
    assign dst_base = {dst_field, {BSEL_W{1'b0}}};
    // bit_target low bits count from the field's top bit downward
    assign bit_pos  = {bit_target[CRI_W-1:BSEL_W], ~bit_target[BSEL_W-1:0]};
    assign src_fld  = cr_in[src_base +: FIELD_W];
    assign dst_old  = cr_in[dst_base +: FIELD_W];
    assign int_bit  = (ra_sel != '0) & int_src[0];
    assign cmp_fld  = (var_e == VAR_I2F) ? {FIELD_W{int_bit}} : src_fld;

    cfu_term_reduce #(.FIELD_W(FIELD_W)) u_reduce (
        .field_in (cmp_fld),
        .mask     (mask),
        .mode     (mode),
        .use_or   (merge),
        .terms    (terms),
        .reduced  (reduced)
    );

    cfu_field_merge #(.FIELD_W(FIELD_W)) u_merge (
        .terms     (terms),
        .mask      (mask),
        .old_field (dst_old),
        .keep      (merge),
        .new_field (merged)
    );

    // field-0 analysis: negative, positive, zero, summary (result is 0 or 1)
    always_comb begin
        rec_fld                = '0;
        rec_fld[FIELD_W-2]     = reduced;
        rec_fld[FIELD_W-3]     = ~reduced;
        rec_fld[0]             = so_in;
    end

    always_comb begin
        st_d        = st_q;
        st_d.cr_wr  = 1'b0;
        st_d.int_wr = 1'b0;
        if (op_valid) begin
            st_d.cr = cr_in;
            st_d.iv = '0;
            unique case (var_e)
                VAR_F2I: begin
                    st_d.iv[0]  = reduced;
                    st_d.int_wr = 1'b1;
                    if (rc) begin
                        st_d.cr[FIELD_W-1:0] = rec_fld;
                        st_d.cr_wr           = 1'b1;
                    end
                end
                VAR_I2F, VAR_F2F: begin
                    st_d.cr[dst_base +: FIELD_W] = merged;
                    st_d.cr_wr                   = 1'b1;
                end
                VAR_F2B: begin
                    st_d.cr[bit_pos] = reduced;
                    st_d.cr_wr       = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cr_new  = st_q.cr;
    assign int_res = st_q.iv;
    assign cr_wr   = st_q.cr_wr;
    assign int_wr  = st_q.int_wr;
endmodule

// File: rtl/cond_field_unit_chk.sv
module cond_field_unit_chk #(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 8,
    parameter int XLEN       = 64
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  op_valid,
    input logic [1:0]                            variant,
    input logic                                  rc,
    input logic [$clog2(NUM_FIELDS)-1:0]         dst_field,
    input logic [FIELD_W*NUM_FIELDS-1:0]         cr_in,
    input logic [FIELD_W*NUM_FIELDS-1:0]         cr_new,
    input logic [XLEN-1:0]                       int_res,
    input logic                                  cr_wr,
    input logic                                  int_wr
);
    localparam int CR_W = FIELD_W * NUM_FIELDS;
    localparam logic [CR_W-1:0] NIB = {{(CR_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!cr_wr && !int_wr && $stable(cr_new) && $stable(int_res)));

    p_intwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (int_wr == ($past(variant) == 2'b00)));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr |-> (int_res[XLEN-1:1] == '0));

    p_norc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && variant == 2'b00 && !rc) |=> (!cr_wr && cr_new == $past(cr_in)));

    p_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && variant == 2'b10) |=> ($countones(cr_new ^ $past(cr_in)) <= 1));

    p_other_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && variant[0]) |=>
        (((cr_new ^ $past(cr_in)) & ~(NIB << ($past(dst_field) * FIELD_W))) == '0));
endmodule

bind cond_field_unit cond_field_unit_chk #(
    .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .XLEN(XLEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .variant(variant), .rc(rc),
    .dst_field(dst_field), .cr_in(cr_in), .cr_new(cr_new), .int_res(int_res),
    .cr_wr(cr_wr), .int_wr(int_wr)
);

// File: tb/tb_cond_field_unit.sv
module tb_cond_field_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  variant = '0;
    logic        merge = 1'b0, rc = 1'b0, so_in = 1'b0;
    logic [3:0]  mask = '0, mode = '0;
    logic [2:0]  src_field = '0, dst_field = '0;
    logic [4:0]  bit_target = '0, ra_sel = '0;
    logic [63:0] int_src = '0;
    logic [31:0] cr_in = '0;
    logic [31:0] cr_new;
    logic [63:0] int_res;
    logic        cr_wr, int_wr;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cond_field_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .variant(variant),
        .merge(merge), .rc(rc), .mask(mask), .mode(mode),
        .src_field(src_field), .dst_field(dst_field), .bit_target(bit_target),
        .ra_sel(ra_sel), .int_src(int_src), .so_in(so_in), .cr_in(cr_in),
        .cr_new(cr_new), .int_res(int_res), .cr_wr(cr_wr), .int_wr(int_wr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference: issue one op, compute expected result independently, compare
    task automatic run_op(input logic [1:0] v, input logic m, input logic r,
                          input logic [3:0] mk, input logic [3:0] md,
                          input logic [2:0] sf, input logic [2:0] df,
                          input logic [4:0] tg, input logic [4:0] rs,
                          input logic [63:0] is, input logic so,
                          input logic [31:0] c, input string req);
        logic [3:0] src, t, nf;
        logic       red, ecw, eiw;
        logic [31:0] ecr;
        logic [63:0] eint;
        @(negedge clk);
        op_valid = 1'b1; variant = v; merge = m; rc = r; mask = mk; mode = md;
        src_field = sf; dst_field = df; bit_target = tg; ra_sel = rs;
        int_src = is; so_in = so; cr_in = c;
        src = (v == 2'b01) ? {4{(rs != 0) && is[0]}} : c[sf*4 +: 4];
        for (int i = 0; i < 4; i++) t[i] = mk[i] && (md[i] == src[i]);
        red = m ? (t != 0) : (t == 4'hF);
        ecr = c; eint = '0; ecw = 1'b0; eiw = 1'b0;
        case (v)
            2'b00: begin
                eint[0] = red; eiw = 1'b1;
                if (r) begin ecr[3:0] = {1'b0, red, !red, so}; ecw = 1'b1; end
            end
            2'b10: begin ecr[tg[4:2]*4 + 3 - tg[1:0]] = red; ecw = 1'b1; end
            default: begin
                nf = t | (m ? (c[df*4 +: 4] & ~mk) : 4'h0);
                ecr[df*4 +: 4] = nf; ecw = 1'b1;
            end
        endcase
        @(posedge clk); #1;
        op_valid = 1'b0;
        check({req, " cr"}, 64'(cr_new), 64'(ecr));
        check({req, " int"}, int_res, eint);
        check({req, " cr_wr"}, 64'(cr_wr), 64'(ecw));
        check({req, " int_wr"}, 64'(int_wr), 64'(eiw));
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        check("R1 cr", 64'(cr_new), 64'h0);
        check("R1 int", int_res, 64'h0);
        check("R1 wr", 64'({cr_wr, int_wr}), 64'h0);
    endtask

    task automatic sweep(input logic [1:0] v, input string req);
        for (int m = 0; m < 2; m++)
            for (int mk = 0; mk < 16; mk++)
                for (int md = 0; md < 16; md++)
                    run_op(v, 1'(m), 1'b0, 4'(mk), 4'(md), 3'($urandom),
                           3'($urandom), 5'($urandom), 5'($urandom_range(1, 31)),
                           {$urandom, $urandom}, 1'($urandom), $urandom, req);
    endtask

    task automatic t_record();
        for (int k = 0; k < 64; k++)
            run_op(2'b00, 1'(k), 1'b1, 4'(k >> 2), 4'($urandom), 3'(k), 3'h0,
                   5'h0, 5'h1, 64'h0, 1'(k >> 1), $urandom, "R4");
    endtask

    task automatic t_imm();
        // zero selector: int_src LSB set but must be ignored
        for (int k = 0; k < 32; k++)
            run_op(2'b01, 1'(k), 1'b0, 4'(k >> 1), 4'($urandom), 3'h0, 3'(k),
                   5'h0, 5'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, $urandom, "R5");
    endtask

    task automatic t_bit_targets();
        for (int tg = 0; tg < 32; tg++)
            run_op(2'b10, 1'b1, 1'b0, 4'hF, 4'($urandom), 3'($urandom), 3'h0,
                   5'(tg), 5'h1, 64'h0, 1'b0, $urandom, "R8");
    endtask

    task automatic t_idle();
        logic [31:0] c0;
        logic [63:0] i0;
        run_op(2'b00, 1'b1, 1'b1, 4'hF, 4'h0, 3'h2, 3'h0, 5'h0, 5'h1, 64'h0, 1'b1,
               32'h0000_0F00, "R9");
        c0 = cr_new; i0 = int_res;
        @(negedge clk); cr_in = 32'hDEAD_BEEF; variant = 2'b11;
        @(posedge clk); #1;
        check("R9 idle wr", 64'({cr_wr, int_wr}), 64'h0);
        check("R9 idle cr hold", 64'(cr_new), 64'(c0));
        check("R9 idle int hold", int_res, i0);
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R1 cr in reset", 64'(cr_new), 64'h0);
        end
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        sweep(2'b00, "R2 R3");
        sweep(2'b01, "R2 R5 R7");
        sweep(2'b10, "R2 R8");
        sweep(2'b11, "R2 R6 R7");
        t_record();
        t_imm();
        t_bit_targets();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule